// File: doc/BRIEF.md
# Phase-Interleaved Link Slot Scheduler

This block schedules transmissions across a rectangular grid of parallel short-range links so that two links sitting next to each other never drive their coils at the same time. Each link clock period is cut into equal phase slots. Every link owns exactly one slot, chosen from its row and column. The block raises that link's transmit enable only while the current slot matches its own and only if the link has data ready.

The block runs on the fast phase clock. The link clock edge reaches it as a one-cycle `cycle_start` strobe that is synchronous to the phase clock, and the strobe realigns the slot counter to slot 0. A mode input selects either four-phase interleaving, with four slots and the strongest isolation, or two-phase interleaving, with two slots. The two-phase mode shortens the schedule and gives less isolation. Link `i` sits at row `i / COLS` and column `i % COLS`.

Top module: `lsched_top`

## Requirements
- R1: While `rst_n` is low, `phase_idx` is 0 and every bit of `tx_en` is 0, whatever `data_ready` holds.
- R2: A clock edge with `cycle_start` high makes `phase_idx` equal to 0 after that edge, in either mode.
- R3: In four-phase mode (`four_phase` = 1), with no `cycle_start`, `phase_idx` steps 0, 1, 2, 3 and then back to 0 on successive clock edges.
- R4: In two-phase mode (`four_phase` = 0), with no `cycle_start`, `phase_idx` steps 0, 1, 0. A value of 2 or 3 left over from four-phase mode returns to 0 on the next edge.
- R5: In four-phase mode, the link at (row, col) owns slot 2·(row mod 2) + (col mod 2).
- R6: In two-phase mode, the link at (row, col) owns slot (row + col) mod 2. No link is enabled while `phase_idx` is 2 or 3.
- R7: `tx_en[i]` is 1 exactly when `data_ready[i]` is 1 and `phase_idx` equals the slot that link `i` owns. A link whose ready bit is low stays disabled, including during its own slot.
- R8: No two orthogonally adjacent links, whether in the same row or the same column, are enabled in the same cycle.
- R9: With all links ready and no `cycle_start`, each link is enabled in exactly one of every N consecutive cycles, where N is 4 or 2 according to the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | One-cycle strobe marking the link clock edge |
| four_phase | input | 1 | 1 selects four slots per cycle, 0 selects two |
| data_ready | input | ROWS*COLS | Per-link data-ready bits, index row*COLS+col |
| tx_en | output | ROWS*COLS | Per-link transmit enable, index row*COLS+col |
| phase_idx | output | 2 | Current slot number |

## Verification
The slot counter is the only state in the block. A wrong counter value shows up on `phase_idx` in the same cycle. It also moves the whole enable pattern on `tx_en` in that cycle, because the enables follow the counter through logic alone. A wrong slot mapping shows up as soon as the affected link is ready during a slot it should not own, and the adjacency check then flags any pair of neighbours enabled together. Mode switches made while the counter sits at slot 2 or 3 are exercised on purpose, because a counter that fails to wrap would leave every link silent for a stretch of cycles.

// File: rtl/lsched_pkg.sv
package lsched_pkg;

    localparam int PHASE_W = 2;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef struct packed {
        phase_t phase;
    } ctr_state_t;

    // slot owned by the link at (row, col) for the selected interleave mode
    function automatic phase_t slot_of(input int row, input int col, input logic four);
        phase_t s;
        if (four) begin
            s = phase_t'(2 * (row % 2) + (col % 2));
        end else begin
            s = phase_t'((row + col) % 2);
        end
        return s;
    endfunction

endpackage

// File: rtl/lsched_phase_ctr.sv
module lsched_phase_ctr
    import lsched_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cycle_start,
    input  logic   four_phase,
    output phase_t phase_o
);

    ctr_state_t st_d, st_q;
    phase_t     last_slot;

    always_comb begin
        st_d      = st_q;
        last_slot = four_phase ? phase_t'(3) : phase_t'(1);
        if (cycle_start) begin
            st_d.phase = '0;
        end else if (st_q.phase >= last_slot) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + phase_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

    assert_realign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> (phase_o == '0));

    assert_four_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_start && four_phase && phase_o != phase_t'(3))
            |=> (phase_o == $past(phase_o) + phase_t'(1)));

    assert_two_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_start && !four_phase && phase_o != '0) |=> (phase_o == '0));

endmodule

// File: rtl/lsched_slot_map.sv
module lsched_slot_map
    import lsched_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int NLINK = ROWS * COLS
) (
    input  logic               four_phase,
    output phase_t [NLINK-1:0] slot_o
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam phase_t SLOT4 = slot_of(r, c, 1'b1);
            localparam phase_t SLOT2 = slot_of(r, c, 1'b0);
            assign slot_o[r*COLS + c] = four_phase ? SLOT4 : SLOT2;
        end
    end

endmodule

// File: rtl/lsched_gate.sv
module lsched_gate
    import lsched_pkg::*;
#(
    parameter int NLINK = 16
) (
    input  logic               active,
    input  phase_t             phase,
    input  phase_t [NLINK-1:0] slot,
    input  logic   [NLINK-1:0] ready,
    output logic   [NLINK-1:0] en_o
);

    for (genvar i = 0; i < NLINK; i++) begin : g_link
        assign en_o[i] = active && ready[i] && (slot[i] == phase);
    end

endmodule

// File: rtl/lsched_top.sv
module lsched_top
    import lsched_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int NLINK = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_start,
    input  logic             four_phase,
    input  logic [NLINK-1:0] data_ready,
    output logic [NLINK-1:0] tx_en,
    output logic [1:0]       phase_idx
);

    phase_t             phase;
    phase_t [NLINK-1:0] slot;

    lsched_phase_ctr u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .four_phase  (four_phase),
        .phase_o     (phase)
    );

    lsched_slot_map #(.ROWS(ROWS), .COLS(COLS)) u_map (
        .four_phase (four_phase),
        .slot_o     (slot)
    );

    lsched_gate #(.NLINK(NLINK)) u_gate (
        .active (rst_n),
        .phase  (phase),
        .slot   (slot),
        .ready  (data_ready),
        .en_o   (tx_en)
    );

    assign phase_idx = phase;

    // R1: no enable while held in reset
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (tx_en == '0);
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_chk_row
        for (genvar c = 0; c < COLS; c++) begin : g_chk_col
            localparam int IDX = r * COLS + c;

            assert_ready_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !data_ready[IDX] |-> !tx_en[IDX]);

            if (c < COLS - 1) begin : g_right
                assert_no_adjacent_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    !(tx_en[IDX] && tx_en[IDX + 1]));
            end
            if (r < ROWS - 1) begin : g_down
                assert_no_adjacent_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    !(tx_en[IDX] && tx_en[IDX + COLS]));
            end
        end
    end

    assert_two_phase_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!four_phase && phase_idx >= 2'd2) |-> (tx_en == '0));

endmodule

// File: tb/tb_lsched_top.sv
module tb_lsched_top;

    localparam int ROWS   = 4;
    localparam int COLS   = 4;
    localparam int NLINK  = ROWS * COLS;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cycle_start;
    logic             four_phase;
    logic [NLINK-1:0] data_ready;
    logic [NLINK-1:0] tx_en;
    logic [1:0]       phase_idx;

    int checks = 0;
    int errors = 0;
    int exp_phase = 0;
    int cyc = 0;
    bit done = 1'b0;

    lsched_top #(.ROWS(ROWS), .COLS(COLS)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .four_phase  (four_phase),
        .data_ready  (data_ready),
        .tx_en       (tx_en),
        .phase_idx   (phase_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int slot_fn(input int r, input int c, input bit four);
        return four ? (2 * (r % 2) + (c % 2)) : ((r + c) % 2);
    endfunction

    function automatic logic [NLINK-1:0] exp_en(input int ph, input bit four,
                                                 input logic [NLINK-1:0] rdy);
        logic [NLINK-1:0] e = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                e[r*COLS+c] = rdy[r*COLS+c] && (slot_fn(r, c, four) == ph);
        return e;
    endfunction

    function automatic bit adj_clash(input logic [NLINK-1:0] en);
        bit bad = 1'b0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                if (c < COLS-1 && en[r*COLS+c] && en[r*COLS+c+1]) bad = 1'b1;
                if (r < ROWS-1 && en[r*COLS+c] && en[(r+1)*COLS+c]) bad = 1'b1;
            end
        return bad;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // one clock: inputs already set at negedge; update model, check after edge
    task automatic step(input bit cs, input bit four, input logic [NLINK-1:0] rdy);
        int last;
        cycle_start = cs;
        four_phase  = four;
        data_ready  = rdy;
        @(posedge clk);
        #1;
        cyc++;
        last = four ? 3 : 1;
        if (cs) exp_phase = 0;
        else if (exp_phase >= last) exp_phase = 0;
        else exp_phase = exp_phase + 1;
        if (cs) check(phase_idx == 2'd0, "R2", phase_idx, 0);
        else check(int'(phase_idx) == exp_phase, four ? "R3" : "R4", phase_idx, exp_phase);
        check(tx_en == exp_en(exp_phase, four, rdy), four ? "R5 R7" : "R6 R7",
              tx_en, exp_en(exp_phase, four, rdy));
        check(!adj_clash(tx_en), "R8", tx_en, 0);
        @(negedge clk);
    endtask

    initial begin
        int seed;
        int hits [NLINK];
        seed = $urandom(32'd20241);
        rst_n = 1'b0; cycle_start = 1'b0; four_phase = 1'b1; data_ready = '1;
        repeat (3) @(negedge clk);
        check(phase_idx == 2'd0, "R1 phase", phase_idx, 0);
        check(tx_en == '0, "R1 tx_en", tx_en, 0);
        rst_n = 1'b1;
        exp_phase = 0;
        @(negedge clk);
        exp_phase = -1;
        // realign so the model is aligned: cycle_start forces slot 0
        step(1'b1, 1'b1, '1);

        // R9: four-phase, all ready, each link exactly once per 4 cycles
        for (int i = 0; i < NLINK; i++) hits[i] = 0;
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b1, '1);
            for (int i = 0; i < NLINK; i++) if (tx_en[i]) hits[i]++;
        end
        for (int i = 0; i < NLINK; i++) check(hits[i] == 1, "R9 four", hits[i], 1);

        // R9: two-phase window of 2
        step(1'b1, 1'b0, '1);
        for (int i = 0; i < NLINK; i++) hits[i] = 0;
        for (int k = 0; k < 2; k++) begin
            step(1'b0, 1'b0, '1);
            for (int i = 0; i < NLINK; i++) if (tx_en[i]) hits[i]++;
        end
        for (int i = 0; i < NLINK; i++) check(hits[i] == 1, "R9 two", hits[i], 1);

        // R4 corner: switch to two-phase while at slot 2 or 3
        step(1'b1, 1'b1, '1);
        step(1'b0, 1'b1, '1);
        step(1'b0, 1'b1, '1);          // phase 2
        step(1'b0, 1'b0, '1);          // leftover 2 -> 0
        check(phase_idx == 2'd0, "R4 leftover", phase_idx, 0);
        step(1'b1, 1'b1, '1);
        step(1'b0, 1'b1, '1);
        step(1'b0, 1'b1, '1);
        step(1'b0, 1'b1, '1);          // phase 3
        step(1'b0, 1'b0, '1);
        check(phase_idx == 2'd0, "R4 leftover3", phase_idx, 0);

        // R7: one ready link at a time, full sweep in each mode
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < NLINK; i++) begin
                logic [NLINK-1:0] one = '0;
                one[i] = 1'b1;
                step(1'b1, m[0], one);
                for (int k = 0; k < 4; k++) step(1'b0, m[0], one);
            end

        // R7: no ready at all, nothing enabled
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 1'b1, '0);
            check(tx_en == '0, "R7 idle", tx_en, 0);
        end

        // random mix of modes, strobes and ready bits
        for (int k = 0; k < 1500; k++) begin
            bit cs   = ($urandom % 7) == 0;
            bit four = ($urandom % 5) != 0;
            logic [NLINK-1:0] rdy = NLINK'($urandom);
            step(cs, four, rdy);
        end

        // R1 again: reset mid-run
        rst_n = 1'b0;
        data_ready = '1;
        @(posedge clk); #1;
        check(phase_idx == 2'd0, "R1 mid", phase_idx, 0);
        check(tx_en == '0, "R1 mid tx", tx_en, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule